// File: doc/BRIEF.md
# Resettable Symbol Stream Descrambler

This block removes the scrambling from a received stream of 8-bit symbols, each tagged with a flag marking it as a control symbol. A 16-bit linear feedback shift register runs alongside the stream and supplies one mask byte per symbol. Data symbols are XORed with that mask. Control symbols go through untouched. A comma control symbol puts the register back to its all-ones seed, so both ends of the link stay in step.

The register advances on every valid symbol, control or data, except a comma, which reloads it instead. When valid is low it holds. An enable input turns the XOR off, for a receiver whose PHY already descrambles. The register keeps running while descrambling is off, so turning it back on mid-stream stays aligned. Symbol, flag and valid all come out through one register stage.

Top module: `sym_descrambler`

## Requirements
- R1: While reset is asserted and in the cycle after it ends, out_valid, out_k and out_sym are all zero. The register starts from 16'hFFFF, so the first data symbol after reset is unmasked with the seed mask.
- R2: A data symbol (in_k = 0) with descr_en = 1 comes out as in_sym XOR mask. Mask bit i (i = 0 first, the least significant bit) is bit 15 of the register before shift i. Each shift moves the register left by one and, when the bit shifted out was 1, XORs it with 16'h0039. This is the polynomial x^16 + x^5 + x^4 + x^3 + 1. Eight shifts are made per symbol.
- R3: A control symbol (in_k = 1) comes out with out_sym equal to in_sym and out_k = 1.
- R4: A comma (in_k = 1 and in_sym = 8'hBC) reloads the register with 16'hFFFF. The next data symbol is unmasked with the seed mask, whatever came before.
- R5: A control symbol other than the comma advances the register by eight shifts, as a data symbol does.
- R6: A cycle with in_valid = 0 leaves the register unchanged and gives out_valid = 0 one cycle later.
- R7: With descr_en = 0, every valid symbol comes out unchanged. The register still advances and reloads as in R4 and R5, so descrambling is correct again as soon as descr_en returns to 1.
- R8: Outputs have a latency of exactly one clock cycle. out_k and out_valid belong to the same symbol as out_sym.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sym | input | 8 | Received symbol |
| in_k | input | 1 | Control symbol flag |
| in_valid | input | 1 | Symbol qualifier |
| descr_en | input | 1 | 1 = descramble data symbols, 0 = pass everything through |
| out_sym | output | 8 | Descrambled symbol |
| out_k | output | 1 | Delayed control flag |
| out_valid | output | 1 | Delayed qualifier |

## Verification
Data symbols straight after reset and straight after a comma check the seed mask and the shift direction. A long run of data, with non-comma control symbols mixed in, separates a register that advances on control symbols from one that skips them. Gaps in valid show whether the register holds or drifts. A stretch with descrambling disabled, followed by re-enabling, shows whether the register kept running while bypassed. A second comma in the middle of the stream shows that the reload overrides the advance.

// File: rtl/descr_pkg.sv
package descr_pkg;
  parameter int SYM_W  = 8;
  parameter int LFSR_W = 16;

  typedef logic [SYM_W-1:0]  sym_t;
  typedef logic [LFSR_W-1:0] lfsr_t;

  // one Galois shift: msb leaves, taps folded back when it was set
  function automatic lfsr_t lfsr_step(input lfsr_t s, input lfsr_t taps);
    return {s[LFSR_W-2:0], 1'b0} ^ (s[LFSR_W-1] ? taps : '0);
  endfunction

  // mask byte for one symbol, lsb produced first
  function automatic sym_t lfsr_mask(input lfsr_t s, input lfsr_t taps);
    sym_t  m;
    lfsr_t t;
    t = s;
    for (int i = 0; i < SYM_W; i++) begin
      m[i] = t[LFSR_W-1];
      t    = lfsr_step(t, taps);
    end
    return m;
  endfunction

  // register state after one full symbol of shifts
  function automatic lfsr_t lfsr_advance(input lfsr_t s, input lfsr_t taps);
    lfsr_t t;
    t = s;
    for (int i = 0; i < SYM_W; i++) t = lfsr_step(t, taps);
    return t;
  endfunction
endpackage

// File: rtl/descr_lfsr.sv
module descr_lfsr
  import descr_pkg::*;
#(
  parameter lfsr_t TAPS = 16'h0039,
  parameter lfsr_t SEED = 16'hFFFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  reload,
  output lfsr_t state_q,
  output sym_t  mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= SEED;
    else if (reload) state_q <= SEED;
    else if (adv)    state_q <= lfsr_advance(state_q, TAPS);
  end

  assign mask = lfsr_mask(state_q, TAPS);

  a_r4_reload_seed: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> state_q == SEED);
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !reload) |=> $stable(state_q));
  a_r5_moves_on_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reload) |=> state_q != $past(state_q));
endmodule

// File: rtl/descr_xor.sv
module descr_xor
  import descr_pkg::*;
(
  input  sym_t sym,
  input  logic is_k,
  input  logic en,
  input  sym_t mask,
  output sym_t result
);
  logic apply;
  assign apply = en && !is_k;

  for (genvar b = 0; b < SYM_W; b++) begin : g_bit
    assign result[b] = sym[b] ^ (apply & mask[b]);
  end
endmodule

// File: rtl/sym_descrambler.sv
module sym_descrambler
  import descr_pkg::*;
#(
  parameter lfsr_t TAPS  = 16'h0039,
  parameter lfsr_t SEED  = 16'hFFFF,
  parameter sym_t  COMMA = 8'hBC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] in_sym,
  input  logic             in_k,
  input  logic             in_valid,
  input  logic             descr_en,
  output logic [SYM_W-1:0] out_sym,
  output logic             out_k,
  output logic             out_valid
);
  logic  comma_hit;
  logic  lfsr_adv;
  lfsr_t lfsr_q;
  sym_t  cur_mask;
  sym_t  xor_out;

  assign comma_hit = in_valid && in_k && (in_sym == COMMA);
  assign lfsr_adv  = in_valid && !comma_hit;

  descr_lfsr #(.TAPS(TAPS), .SEED(SEED)) lfsr_i (
    .clk(clk), .rst_n(rst_n), .adv(lfsr_adv), .reload(comma_hit),
    .state_q(lfsr_q), .mask(cur_mask)
  );

  descr_xor xor_i (
    .sym(in_sym), .is_k(in_k), .en(descr_en), .mask(cur_mask), .result(xor_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_sym   <= '0;
      out_k     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sym <= xor_out;
        out_k   <= in_k;
      end
    end
  end

  a_r3_k_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_k) |=> (out_k && out_sym == $past(in_sym)));
  a_r7_bypass_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !descr_en) |=> out_sym == $past(in_sym));
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r6_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_data_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_k) |=> !out_k);
endmodule

// File: tb/sym_descrambler_tb_top.sv
`timescale 1ns/1ps
module sym_descrambler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] in_sym;
  logic       in_k, in_valid, descr_en;
  logic [7:0] out_sym;
  logic       out_k, out_valid;

  int tests = 0;
  int fails = 0;
  logic [15:0] model;

  always #2.5 clk = ~clk;

  sym_descrambler dut_i (
    .clk(clk), .rst_n(rst_n), .in_sym(in_sym), .in_k(in_k),
    .in_valid(in_valid), .descr_en(descr_en),
    .out_sym(out_sym), .out_k(out_k), .out_valid(out_valid)
  );

  // independent restatement: bit by bit, feedback taps at 5,4,3,0
  function automatic logic [7:0] m_mask(input logic [15:0] s);
    logic [7:0] m;
    logic [15:0] t;
    logic fb;
    t = s;
    for (int i = 0; i < 8; i++) begin
      fb = t[15];
      m[i] = fb;
      t = t << 1;
      if (fb) t = t ^ ((16'h1 << 5) | (16'h1 << 4) | (16'h1 << 3) | 16'h1);
    end
    return m;
  endfunction

  function automatic logic [15:0] m_next(input logic [15:0] s);
    logic [15:0] t;
    logic fb;
    t = s;
    for (int i = 0; i < 8; i++) begin
      fb = t[15];
      t = t << 1;
      if (fb) t = t ^ 16'h0039;
    end
    return t;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle and check the registered result
  task automatic send(input string req, input logic [7:0] s, input logic k,
                      input logic v, input logic en);
    logic [7:0] exp;
    @(negedge clk);
    in_sym = s; in_k = k; in_valid = v; descr_en = en;
    exp = s;
    if (v) begin
      if (k && s == 8'hBC) model = 16'hFFFF;
      else begin
        if (en && !k) exp = s ^ m_mask(model);
        model = m_next(model);
      end
    end
    @(posedge clk); #1;
    check({req, " valid"}, {15'd0, out_valid}, {15'd0, v});
    if (v) begin
      check({req, " sym"}, {8'd0, out_sym}, {8'd0, exp});
      check({req, " k"}, {15'd0, out_k}, {15'd0, k});
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_sym = 8'h5A; in_k = 1'b0; in_valid = 1'b0; descr_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid in reset", {15'd0, out_valid}, 16'd0);
    check("R1 out_sym in reset", {8'd0, out_sym}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 out_k after reset", {15'd0, out_k}, 16'd0);
    model = 16'hFFFF;
    send("R1 seed mask first data", 8'h00, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_data_run;
    send("R4 comma", 8'hBC, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++)
      send("R2 data run", 8'(i * 37 + 3), 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_k_advance;
    send("R3 skip symbol", 8'h1C, 1'b1, 1'b1, 1'b1);
    send("R5 data after K", 8'hA5, 1'b0, 1'b1, 1'b1);
    send("R3 other K", 8'hF7, 1'b1, 1'b1, 1'b1);
    send("R5 data after second K", 8'h3C, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_idle_hold;
    send("R8 data before gap", 8'h77, 1'b0, 1'b1, 1'b1);
    send("R6 gap", 8'hBC, 1'b1, 1'b0, 1'b1);
    send("R6 gap 2", 8'h12, 1'b0, 1'b0, 1'b1);
    send("R6 data after gap", 8'h99, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_bypass;
    for (int i = 0; i < 4; i++)
      send("R7 bypass data", 8'(8'hC0 + i), 1'b0, 1'b1, 1'b0);
    send("R7 bypass K", 8'h7C, 1'b1, 1'b1, 1'b0);
    send("R7 re-enabled data", 8'h42, 1'b0, 1'b1, 1'b1);
    send("R7 bypass comma", 8'hBC, 1'b1, 1'b1, 1'b0);
    send("R7 reseed seen after bypass", 8'h00, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_reseed;
    for (int i = 0; i < 5; i++) send("R2 pre-comma", 8'(i), 1'b0, 1'b1, 1'b1);
    send("R4 mid comma", 8'hBC, 1'b1, 1'b1, 1'b1);
    send("R4 seed mask again", 8'hFF, 1'b0, 1'b1, 1'b1);
    send("R8 back-to-back", 8'h81, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_data_run();
    t_k_advance();
    t_idle_hold();
    t_bypass();
    t_reseed();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule